// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block watches the data cycles of an 8-bit or 16-bit NAND flash bus and builds a single Hamming-style check code over the whole data area of a page. The code covers 512, 1024, 2048 or 4096 data bytes in one step. It does not work in fixed-size chunks. During a page program, software reads the two 16-bit accumulators once the data has gone out and stores them as four code bytes in the spare area.

During a page read, the four stored code bytes must follow the last data word directly. The block folds them into the same accumulators, which then hold the syndrome. A small classifier turns the syndrome into three flags:

- a correctable single-bit error in the data, with its word address and bit offset readable in the parity register;
- an error confined to the code bytes;
- an uncorrectable multi-bit error.

A freshly erased page, with all data and code bits set, gives a distinctive pattern: the multi-bit flag with every location bit set. Software can recognise this pattern as a clean page.

Software reaches the block through a small register port with a write strobe, an address and combinational read data. Address and command latch cycles on the NAND bus never enter the code.

Top module: `nand_ecc_engine`

## Requirements
- R1: Register 1 (mode) selects the data area size with bits [1:0]: 0 = 512, 1 = 1024, 2 = 2048, 3 = 4096 bytes. Bit 4 selects a 16-bit bus. The data area is that many bus words on an 8-bit bus and half as many on a 16-bit bus. On an 8-bit bus data lanes [15:8] are ignored. The mode register reads back bits [1:0] and 4 and is 0 after reset.
- R2: For every set bit of an accepted data word, the parity accumulator is XORed with the 16-bit index {word number[11:0], bit number[3:0]} and the complementary accumulator with the bitwise inverse of that index. Both are readable in bits [15:0] of registers 3 and 4 in the cycle after each bus cycle.
- R3: The 4 code bytes are taken from the accepted cycles that directly follow the last data word. On an 8-bit bus they arrive in 4 cycles on lanes [7:0]; on a 16-bit bus in 2 cycles, low byte on lanes [7:0]. In order, they are XORed into parity [7:0], parity [15:8], complementary [7:0] and complementary [15:8].
- R4: A page read back with its correct code leaves register 2 (flags) at 0 and both accumulators at 0.
- R5: A single flipped data bit sets flag bit 0 (recoverable) alone. The parity register then holds the bit offset in [3:0] and the word address in [15:4].
- R6: A single flipped code bit sets flag bits 0 and 2 (code error) and leaves bit 1 clear.
- R7: Any other nonzero syndrome sets flag bits 0 and 1 (multiple error). This is the case when the two accumulators are not exact complements and together hold more than one set bit. An erased page with all-ones code gives flags 3 with parity 16'hFFFF.
- R8: A bus cycle with the address latch or command latch input high changes no counter and no accumulator.
- R9: Bus cycles after the fourth code byte change nothing until the next clear.
- R10: Writing register 0 with bit 0 set clears both accumulators, the flags and the cycle counters. The mode register is left as it was.
- R11: The flags read 0 until all 4 code bytes of a page have been absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nand_strobe | input | 1 | One-cycle pulse marking a NAND bus transfer |
| nand_ale | input | 1 | Address latch enable level during the transfer |
| nand_cle | input | 1 | Command latch enable level during the transfer |
| nand_data | input | BUS_W | Bus word of the transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_ADDR_W | Register address (0 control, 1 mode, 2 flags, 3 parity, 4 complementary) |
| reg_wdata | input | REG_DATA_W | Register write data |
| reg_rdata | output | REG_DATA_W | Register read data, combinational on reg_addr |

## Verification
The bench targets the placement of a flipped bit at both index extremes, word 0 bit 0 and the last word of a 4096-byte page at bit 7. An off-by-one word counter or a missing complement term would report a wrong location or raise the multi-bit flag there. It flips one bit in each half of the stored code to expose a wrong byte order, which would move the syndrome bit or turn a code error into a multi error. It injects latch cycles inside the data stream and extra cycles after the code, either of which would shift the page boundary and corrupt every later accumulator value. The erased-page pattern, the 16-bit lane folding, and garbage on the upper lanes of an 8-bit bus are each covered, since a wrong lane mask would break parity on the very first word.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   localparam int unsigned CODE_BYTES = 4;

   typedef enum logic [1:0] {
      PG_512 = 2'd0,
      PG_1K  = 2'd1,
      PG_2K  = 2'd2,
      PG_4K  = 2'd3
   } page_sel_e;

   typedef struct packed {
      logic code_err;
      logic multi_err;
      logic recov_err;
   } ecc_flags_t;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_MODE  = 3'd1;
   localparam logic [2:0] RA_FLAGS = 3'd2;
   localparam logic [2:0] RA_PAR   = 3'd3;
   localparam logic [2:0] RA_CPAR  = 3'd4;

   localparam int unsigned MODE_WIDE_BIT = 4;

endpackage

// File: rtl/nand_ecc_cycle_qual.sv
module nand_ecc_cycle_qual
   import nand_ecc_pkg::*;
#(
   parameter int unsigned CNT_W   = 13,
   parameter int unsigned WADDR_W = 12,
   parameter int unsigned POS_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               strobe,
   input  logic               ale,
   input  logic               cle,
   input  logic               wide,
   input  logic [CNT_W-1:0]   page_words,
   output logic               data_en,
   output logic               code_en,
   output logic [WADDR_W-1:0] word_idx,
   output logic [POS_W-1:0]   code_pos,
   output logic               done
);

   localparam logic [POS_W-1:0] CODE_END = POS_W'(CODE_BYTES);

   logic [CNT_W-1:0] word_q;
   logic [POS_W-1:0] pos_q;
   logic             accept;
   logic             in_data;
   logic             in_code;

   always_comb begin
      accept  = strobe & ~ale & ~cle;
      in_data = word_q < page_words;
      in_code = ~in_data & (pos_q < CODE_END);
      data_en = accept & in_data;
      code_en = accept & in_code;
      done    = ~in_data & (pos_q >= CODE_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         pos_q  <= '0;
      end else if (clr) begin
         word_q <= '0;
         pos_q  <= '0;
      end else begin
         if (data_en) word_q <= word_q + CNT_W'(1);
         if (code_en) pos_q  <= pos_q + (wide ? POS_W'(2) : POS_W'(1));
      end
   end

   assign word_idx = word_q[WADDR_W-1:0];
   assign code_pos = pos_q;

   // latch cycles never advance the page position
   p_latch_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (ale || cle) && !clr) |=> ($stable(word_q) && $stable(pos_q)));

   // once the code is complete, counters stay put
   p_frozen_after_code_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> ($stable(word_q) && $stable(pos_q)));

   p_pos_bounded_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= CODE_END);

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
   parameter int unsigned BUS_W   = 16,
   parameter int unsigned IDX_W   = 16,
   parameter int unsigned BIT_W   = 4,
   parameter int unsigned WADDR_W = 12,
   parameter int unsigned POS_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               data_en,
   input  logic               code_en,
   input  logic               wide,
   input  logic [WADDR_W-1:0] word_idx,
   input  logic [POS_W-1:0]   code_pos,
   input  logic [BUS_W-1:0]   din,
   output logic [IDX_W-1:0]   par,
   output logic [IDX_W-1:0]   cpar
);

   localparam int unsigned CODE_W = 2 * IDX_W;

   logic [BUS_W-1:0]  lane_ok;
   logic [7:0]        hi_byte;
   logic [IDX_W-1:0]  fold_p;
   logic [IDX_W-1:0]  fold_n;
   logic [CODE_W-1:0] code_vec;
   logic [POS_W-1:0]  pos_hi;
   logic [IDX_W-1:0]  par_q;
   logic [IDX_W-1:0]  cpar_q;

   generate
      if (BUS_W > 8) begin : g_wide_lanes
         assign lane_ok = wide ? {BUS_W{1'b1}} : BUS_W'(8'hFF);
         assign hi_byte = din[BUS_W-1 -: 8];
      end else begin : g_narrow_lanes
         assign lane_ok = {BUS_W{1'b1}};
         assign hi_byte = 8'h00;
      end
   endgenerate

   always_comb begin
      fold_p = '0;
      fold_n = '0;
      for (int b = 0; b < BUS_W; b++) begin
         if (din[b] && lane_ok[b]) begin
            fold_p = fold_p ^ {word_idx, BIT_W'(b)};
            fold_n = fold_n ^ ~{word_idx, BIT_W'(b)};
         end
      end
   end

   always_comb begin
      pos_hi   = code_pos + POS_W'(1);
      code_vec = CODE_W'(din[7:0]) << {code_pos, 3'b000};
      if (wide) code_vec = code_vec | (CODE_W'(hi_byte) << {pos_hi, 3'b000});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q  <= '0;
         cpar_q <= '0;
      end else if (clr) begin
         par_q  <= '0;
         cpar_q <= '0;
      end else if (data_en) begin
         par_q  <= par_q ^ fold_p;
         cpar_q <= cpar_q ^ fold_n;
      end else if (code_en) begin
         par_q  <= par_q ^ code_vec[IDX_W-1:0];
         cpar_q <= cpar_q ^ code_vec[CODE_W-1:IDX_W];
      end
   end

   assign par  = par_q;
   assign cpar = cpar_q;

   p_clear_zeroes_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (par_q == '0 && cpar_q == '0));

   p_hold_when_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!data_en && !code_en && !clr) |=> ($stable(par_q) && $stable(cpar_q)));

   // one set data bit moves the two accumulators by complementary amounts
   p_single_bit_pair_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_en && !clr && $countones(din & lane_ok) == 1) |=>
      (((par_q ^ $past(par_q)) ^ (cpar_q ^ $past(cpar_q))) == {IDX_W{1'b1}}));

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
   import nand_ecc_pkg::*;
#(
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [IDX_W-1:0] par,
   input  logic [IDX_W-1:0] cpar,
   output ecc_flags_t       flags
);

   localparam int unsigned SYN_W  = 2 * IDX_W;
   localparam int unsigned ONES_W = $clog2(SYN_W + 1);

   logic [SYN_W-1:0]  syn;
   logic [ONES_W-1:0] ones;
   logic              nonzero;
   logic              complementary;
   logic              single;

   always_comb begin
      syn  = {cpar, par};
      ones = '0;
      for (int i = 0; i < SYN_W; i++) ones = ones + ONES_W'(syn[i]);
      nonzero       = |syn;
      complementary = (par ^ cpar) == {IDX_W{1'b1}};
      single        = ones == ONES_W'(1);
      flags.recov_err = done & nonzero;
      flags.code_err  = done & single;
      flags.multi_err = done & nonzero & ~complementary & ~single;
   end

   p_flags_wait_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (flags == '0));

   p_erased_pattern_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && par == {IDX_W{1'b1}} && cpar == {IDX_W{1'b1}}) |-> flags.multi_err);

   p_code_not_multi_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      flags.code_err |-> (flags.recov_err && !flags.multi_err));

endmodule

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
   import nand_ecc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 3,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned IDX_W        = 16,
   parameter bit          SUPPORT_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  ecc_flags_t        flags,
   input  logic [IDX_W-1:0]  par,
   input  logic [IDX_W-1:0]  cpar,
   output logic              clr,
   output page_sel_e         sel,
   output logic              wide
);

   page_sel_e sel_q;
   logic      wide_q;
   logic      wide_next;
   logic      mode_wr;
   logic      unused_wdata;

   assign mode_wr      = reg_wr && (reg_addr == ADDR_W'(RA_MODE));
   assign clr          = reg_wr && (reg_addr == ADDR_W'(RA_CTRL)) && reg_wdata[0];
   assign unused_wdata = ^reg_wdata;

   generate
      if (SUPPORT_WIDE) begin : g_wide_mode
         assign wide_next = reg_wdata[MODE_WIDE_BIT];
      end else begin : g_narrow_mode
         assign wide_next = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= PG_512;
         wide_q <= 1'b0;
      end else if (mode_wr) begin
         sel_q  <= page_sel_e'(reg_wdata[1:0]);
         wide_q <= wide_next;
      end
   end

   assign sel  = sel_q;
   assign wide = wide_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(RA_MODE): begin
            reg_rdata[1:0]           = sel_q;
            reg_rdata[MODE_WIDE_BIT] = wide_q;
         end
         ADDR_W'(RA_FLAGS): reg_rdata[2:0]       = flags;
         ADDR_W'(RA_PAR):   reg_rdata[IDX_W-1:0] = par;
         ADDR_W'(RA_CPAR):  reg_rdata[IDX_W-1:0] = cpar;
         default:           reg_rdata            = '0;
      endcase
   end

   p_mode_write_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (sel_q == page_sel_e'($past(reg_wdata[1:0]))));

   p_mode_kept_on_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !mode_wr) |=> ($stable(sel_q) && $stable(wide_q)));

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
   import nand_ecc_pkg::*;
#(
   parameter int unsigned BUS_W          = 16,
   parameter int unsigned MAX_DATA_BYTES = 4096,
   parameter int unsigned REG_ADDR_W     = 3,
   parameter int unsigned REG_DATA_W     = 32,
   parameter bit          SUPPORT_WIDE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  nand_strobe,
   input  logic                  nand_ale,
   input  logic                  nand_cle,
   input  logic [BUS_W-1:0]      nand_data,
   input  logic                  reg_wr,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata
);

   localparam int unsigned BIT_W    = 4;
   localparam int unsigned WADDR_W  = $clog2(MAX_DATA_BYTES);
   localparam int unsigned IDX_W    = WADDR_W + BIT_W;
   localparam int unsigned CNT_W    = WADDR_W + 1;
   localparam int unsigned POS_W    = 3;
   localparam bit          WIDE_EFF = SUPPORT_WIDE && (BUS_W > 8);

   generate
      if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_bus
         $error("nand_ecc_engine: BUS_W must be 8 or 16");
      end
      if (MAX_DATA_BYTES != 4096) begin : g_bad_page
         $error("nand_ecc_engine: MAX_DATA_BYTES must be 4096");
      end
      if (IDX_W != 16) begin : g_bad_idx
         $error("nand_ecc_engine: index must be 16 bits for a 4-byte code");
      end
      if (REG_DATA_W < IDX_W || REG_ADDR_W < 3) begin : g_bad_regs
         $error("nand_ecc_engine: register port too narrow");
      end
   endgenerate

   page_sel_e          sel;
   logic               wide;
   logic               clr;
   logic [CNT_W-1:0]   page_bytes;
   logic [CNT_W-1:0]   page_words;
   logic               data_en;
   logic               code_en;
   logic               done;
   logic [WADDR_W-1:0] word_idx;
   logic [POS_W-1:0]   code_pos;
   logic [IDX_W-1:0]   par;
   logic [IDX_W-1:0]   cpar;
   ecc_flags_t         flags;

   assign page_bytes = CNT_W'(512) << sel;
   assign page_words = wide ? (page_bytes >> 1) : page_bytes;

   nand_ecc_regs #(
      .ADDR_W       (REG_ADDR_W),
      .DATA_W       (REG_DATA_W),
      .IDX_W        (IDX_W),
      .SUPPORT_WIDE (WIDE_EFF)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flags     (flags),
      .par       (par),
      .cpar      (cpar),
      .clr       (clr),
      .sel       (sel),
      .wide      (wide)
   );

   nand_ecc_cycle_qual #(
      .CNT_W   (CNT_W),
      .WADDR_W (WADDR_W),
      .POS_W   (POS_W)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .strobe     (nand_strobe),
      .ale        (nand_ale),
      .cle        (nand_cle),
      .wide       (wide),
      .page_words (page_words),
      .data_en    (data_en),
      .code_en    (code_en),
      .word_idx   (word_idx),
      .code_pos   (code_pos),
      .done       (done)
   );

   nand_ecc_accum #(
      .BUS_W   (BUS_W),
      .IDX_W   (IDX_W),
      .BIT_W   (BIT_W),
      .WADDR_W (WADDR_W),
      .POS_W   (POS_W)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .data_en  (data_en),
      .code_en  (code_en),
      .wide     (wide),
      .word_idx (word_idx),
      .code_pos (code_pos),
      .din      (nand_data),
      .par      (par),
      .cpar     (cpar)
   );

   nand_ecc_classify #(
      .IDX_W (IDX_W)
   ) u_classify (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (done),
      .par   (par),
      .cpar  (cpar),
      .flags (flags)
   );

endmodule

// File: tb/test_nand_ecc_engine.sv
module test_nand_ecc_engine;
   import nand_ecc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic        ale = 1'b0;
   logic        cle = 1'b0;
   logic [15:0] data = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = RA_PAR;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   nand_ecc_engine i_nand_ecc_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .nand_strobe (strobe),
      .nand_ale    (ale),
      .nand_cle    (cle),
      .nand_data   (data),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata)
   );

   // reference model state and page configuration
   logic [15:0] mp, mn;
   bit          cfg_wide, cfg_read, cfg_erased, cfg_latch;
   int          cfg_sel, cfg_junk, n_err, code_flip;
   int          ew[2], eb[2];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
      reg_addr = RA_PAR;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      tick();
      reg_wr = 1'b0; reg_addr = RA_PAR; reg_wdata = '0;
   endtask

   function automatic logic [15:0] page_word(input int i);
      logic [31:0] x;
      if (cfg_erased) return cfg_wide ? 16'hFFFF : 16'h00FF;
      x = i * 32'd40503 + 32'd12345;
      x = x ^ (x >> 7);
      return cfg_wide ? x[15:0] : {8'h00, x[7:0]};
   endfunction

   task automatic fold(input int idx, input logic [15:0] d, inout logic [15:0] p, inout logic [15:0] n);
      for (int b = 0; b < (cfg_wide ? 16 : 8); b++) begin
         if (d[b]) begin
            p = p ^ 16'((idx << 4) | b);
            n = n ^ ~16'((idx << 4) | b);
         end
      end
   endtask

   function automatic logic [2:0] exp_flags(input logic [15:0] p, input logic [15:0] n);
      int ones = 0;
      for (int i = 0; i < 16; i++) ones += int'(p[i]) + int'(n[i]);
      if (p == 0 && n == 0) return 3'b000;
      if ((p ^ n) == 16'hFFFF) return 3'b001;
      if (ones == 1) return 3'b101;
      return 3'b011;
   endfunction

   task automatic run_page();
      int          words;
      logic [15:0] cp, cn, d;
      logic [31:0] code, m;
      wr(RA_CTRL, 32'h1);
      wr(RA_MODE, (32'(cfg_wide) << 4) | 32'(cfg_sel));
      words = (512 << cfg_sel) >> int'(cfg_wide);
      cp = '0; cn = '0;
      for (int i = 0; i < words; i++) fold(i, page_word(i), cp, cn);
      code = cfg_erased ? 32'hFFFF_FFFF : {cn, cp};
      if (code_flip >= 0) code[code_flip] = ~code[code_flip];
      mp = '0; mn = '0;
      for (int i = 0; i < words; i++) begin
         d = page_word(i);
         for (int k = 0; k < n_err; k++) if (ew[k] == i) d[eb[k]] = ~d[eb[k]];
         if (cfg_latch && (i % 37) == 5) begin
            strobe = 1'b1; ale = (i % 2) == 0; cle = (i % 2) != 0; data = ~d;
            tick();
            check("R8 latch cycle ignored", {16'h0, reg_rdata[15:0]}, {16'h0, mp});
            ale = 1'b0; cle = 1'b0;
         end
         strobe = 1'b1;
         data = cfg_wide ? d : {8'h5A, d[7:0]};
         @(posedge clk);
         fold(i, d, mp, mn);
         @(negedge clk);
         check("R2 running parity", {16'h0, reg_rdata[15:0]}, {16'h0, mp});
      end
      if (cfg_read) begin
         for (int c = 0; c < (cfg_wide ? 2 : 4); c++) begin
            data = cfg_wide ? code[c*16 +: 16] : {8'hC3, code[c*8 +: 8]};
            @(posedge clk);
            m = {mn, mp};
            m = m ^ (cfg_wide ? (32'(code[c*16 +: 16]) << (16*c)) : (32'(code[c*8 +: 8]) << (8*c)));
            mp = m[15:0]; mn = m[31:16];
            @(negedge clk);
            check("R3 code absorption", {16'h0, reg_rdata[15:0]}, {16'h0, mp});
         end
      end
      for (int j = 0; j < cfg_junk; j++) begin
         data = 16'(j * 16'h1357 + 16'h00F1);
         tick();
         check("R9 cycle beyond page", {16'h0, reg_rdata[15:0]}, {16'h0, mp});
      end
      strobe = 1'b0;
      tick();
   endtask

   task automatic cfg(input int sel, input bit wide, input bit rd_, input bit erased);
      cfg_sel = sel; cfg_wide = wide; cfg_read = rd_; cfg_erased = erased;
      cfg_latch = 1'b0; cfg_junk = 0; n_err = 0; code_flip = -1;
   endtask

   task automatic expect_end(input string tag, input logic [2:0] fl, input logic [15:0] p, input logic [15:0] n);
      logic [31:0] v;
      rd(RA_FLAGS, v); check({tag, " flags"}, v, 32'(fl));
      check({tag, " model flags"}, v, 32'(exp_flags(mp, mn)));
      rd(RA_PAR, v);   check({tag, " parity"}, v, 32'(p));
      rd(RA_CPAR, v);  check({tag, " complementary"}, v, 32'(n));
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state of mode; R11 flags idle
      rd(RA_MODE, v);  check("R1 mode after reset", v, 32'h0);
      rd(RA_FLAGS, v); check("R11 flags after reset", v, 32'h0);
      rd(RA_PAR, v);   check("R2 parity after reset", v, 32'h0);

      // program path, 8-bit 512 with latch cycles mixed in: R2 R8 R11 R1
      cfg(0, 1'b0, 1'b0, 1'b0); cfg_latch = 1'b1;
      run_page();
      rd(RA_MODE, v);  check("R1 mode readback", v, 32'h0);
      rd(RA_FLAGS, v); check("R11 flags before code", v, 32'h0);
      rd(RA_CPAR, v);  check("R2 complementary", v, 32'(mn));

      // clean read, 16-bit 2048: R4 R1
      cfg(2, 1'b1, 1'b1, 1'b0); run_page();
      rd(RA_MODE, v);  check("R1 mode readback wide", v, 32'h12);
      expect_end("R4 clean page", 3'b000, 16'h0000, 16'h0000);

      // single data errors: R5
      cfg(1, 1'b0, 1'b1, 1'b0); n_err = 1; ew[0] = 777; eb[0] = 5; run_page();
      expect_end("R5 word 777 bit 5", 3'b001, 16'h3095, 16'hCF6A);
      cfg(0, 1'b0, 1'b1, 1'b0); n_err = 1; ew[0] = 0; eb[0] = 0; run_page();
      expect_end("R5 word 0 bit 0", 3'b001, 16'h0000, 16'hFFFF);
      cfg(1, 1'b1, 1'b1, 1'b0); n_err = 1; ew[0] = 300; eb[0] = 13; run_page();
      expect_end("R5 wide word 300 bit 13", 3'b001, 16'h12CD, 16'hED32);

      // single code-bit errors: R6 and R3 byte order
      cfg(0, 1'b0, 1'b1, 1'b0); code_flip = 10; run_page();
      expect_end("R6 code bit 10", 3'b101, 16'h0400, 16'h0000);
      cfg(0, 1'b1, 1'b1, 1'b0); code_flip = 20; run_page();
      expect_end("R6 wide code bit 20", 3'b101, 16'h0000, 16'h0010);

      // double data error and erased page: R7
      cfg(2, 1'b0, 1'b1, 1'b0); n_err = 2; ew[0] = 10; eb[0] = 1; ew[1] = 1500; eb[1] = 6; run_page();
      rd(RA_FLAGS, v); check("R7 two data errors", v, 32'h3);
      cfg(0, 1'b0, 1'b1, 1'b1); run_page();
      expect_end("R7 erased page", 3'b011, 16'hFFFF, 16'hFFFF);

      // largest page, last bit, trailing cycles: R1 R5 R9
      cfg(3, 1'b0, 1'b1, 1'b0); n_err = 1; ew[0] = 4095; eb[0] = 7; cfg_junk = 6; run_page();
      expect_end("R9 4096 last bit with trailing cycles", 3'b001, 16'hFFF7, 16'h0008);

      // clear: R10
      wr(RA_CTRL, 32'h1);
      rd(RA_PAR, v);   check("R10 parity cleared", v, 32'h0);
      rd(RA_CPAR, v);  check("R10 complementary cleared", v, 32'h0);
      rd(RA_FLAGS, v); check("R10 flags cleared", v, 32'h0);
      rd(RA_MODE, v);  check("R10 mode kept", v, 32'h3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule